// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers sixty-four interrupt request lines into two banks of thirty-two bits and reduces them to a single interrupt line toward one processor. Every line has a fixed type, chosen at reset from a per-bank pattern. A line of the edge type leaves a sticky event bit behind when it is seen high. A line of the level type is never latched: it contributes to the interrupt only while it is high. A per-bank mask gates both kinds of source.

Software reaches the banks through a small 32-bit register window with separate read and write strobes. Each bank has four words: the latched events, the mask, a write-one-to-clear acknowledge and the live input levels. A parameter selects byte-reversed bus data for big-endian hosts. Reads are combinational on the current state. The interrupt output is registered.

Top module: `dual_bank_intc`

## Requirements
- R1: Input line n drives bank 1-(n/32) at bit n mod 32, so lines 0..31 land in bank 1 and lines 32..63 land in bank 0.
- R2: A line sampled high sets its bit in the bank's level word on that clock edge. It also sets its event bit, unless the bank's level-type pattern marks that bit.
- R3: A line sampled low clears only its level bit. The event bit it set earlier stays set.
- R4: A bank is pending when (events OR (levels AND leveltype)) AND mask is nonzero. The output cpu_irq is the OR of the pending state of both banks.
- R5: The bank index is ((addr - 0x10) mod 4096) >> 4. An index other than 0 or 1 ignores writes and reads as zero. Bank 0 therefore occupies 0x10..0x1F and bank 1 occupies 0x20..0x2F.
- R6: Within a bank, offset 0x0 reads the events, offset 0x4 reads and writes the mask, offset 0x8 is the write-only acknowledge (it reads zero), and offset 0xC reads the levels. Every other offset reads zero and ignores writes.
- R7: A write to the acknowledge offset clears the event bits that are one in the written word. Bits marked level-type are removed from the word first.
- R8: Reset zeroes events, mask and levels in both banks and holds cpu_irq low. The level-type pattern is 0x00000000 for bank 0 and 0x1FF00000 for bank 1.
- R9: With BIG_ENDIAN=1, write data and read data are byte-reversed at the bus. As an example, a mask write of 0x01000000 enables bit 0.
- R10: cpu_irq is registered. It changes on the clock edge that samples an input change, a mask write or an acknowledge write, and not earlier.
- R11: When an event bit is set by a high input and cleared by an acknowledge in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt request lines, sampled every clock |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in the same cycle as a high sample on the same edge-type line. The stimulus holds the line high across the write and then reads the event word back. A second hard case is a level-type bit that survives an all-ones acknowledge while its mask keeps the output high. The stimulus covers it by driving line 20, which falls in bank 1's level-type range. A second instance built with byte reversal shares the bus, so one mask write shows the two endian settings enabling different bits.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int BANK_W = 32;
  typedef logic [BANK_W-1:0] word_t;

  localparam logic [3:0] OFS_EVENTS = 4'h0;
  localparam logic [3:0] OFS_MASK   = 4'h4;
  localparam logic [3:0] OFS_ACK    = 4'h8;
  localparam logic [3:0] OFS_LEVELS = 4'hC;

  function automatic word_t byte_rev(input word_t w);
    byte_rev = {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic bank_pending(input word_t ev, input word_t lv,
                                        input word_t lt, input word_t mk);
    bank_pending = |((ev | (lv & lt)) & mk);
  endfunction

  // The set from the input is applied after the clear, so a set wins.
  function automatic word_t event_next(input word_t ev, input word_t ack,
                                       input word_t lt, input word_t hi);
    event_next = (ev & ~(ack & ~lt)) | (hi & ~lt);
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter word_t LT = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t irq_bits,
  input  logic  mask_we,
  input  logic  ack_we,
  input  word_t wdata,
  output word_t ev_q,
  output word_t mk_q,
  output word_t lv_q,
  output logic  pend_next,
  output logic  pend_now
);
  word_t ev_d, mk_d, ack_val;

  always_comb begin
    ack_val = ack_we ? wdata : '0;
    ev_d    = event_next(ev_q, ack_val, LT, irq_bits);
    mk_d    = mask_we ? wdata : mk_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q <= '0;
      mk_q <= '0;
      lv_q <= '0;
    end else begin
      ev_q <= ev_d;
      mk_q <= mk_d;
      lv_q <= irq_bits;
    end
  end

  assign pend_next = bank_pending(ev_d, irq_bits, LT, mk_d);
  assign pend_now  = bank_pending(ev_q, lv_q, LT, mk_q);

  AST_LT_NEVER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & LT) == '0); // R2
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> (($past(ev_q) & ~ev_q) == '0)); // R3
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lv_q == $past(irq_bits)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_bits != '0) |=> ((ev_q & $past(irq_bits & ~LT)) == $past(irq_bits & ~LT))); // R11
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 12,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  word_t                       bus_wdata,
  output word_t                       bus_rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] ev_all,
  input  logic [NUM_BANKS*BANK_W-1:0] mk_all,
  input  logic [NUM_BANKS*BANK_W-1:0] lv_all,
  output logic [NUM_BANKS-1:0]        mask_we,
  output logic [NUM_BANKS-1:0]        ack_we,
  output word_t                       wdata_n
);
  localparam int SEL_W = ADDR_W - 4;

  logic [ADDR_W-1:0]    rel;
  logic [SEL_W-1:0]     sel;
  logic [3:0]           ofs;
  logic [NUM_BANKS-1:0] hit;
  logic                 sel_ok;
  word_t                rd_native;

  assign rel     = bus_addr - ADDR_W'(16);
  assign sel     = rel[ADDR_W-1:4];
  assign ofs     = bus_addr[3:0];
  assign sel_ok  = |hit;
  assign wdata_n = BIG_ENDIAN ? byte_rev(bus_wdata) : bus_wdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign hit[b]     = (sel == SEL_W'(b));
    assign mask_we[b] = bus_wr && hit[b] && (ofs == OFS_MASK);
    assign ack_we[b]  = bus_wr && hit[b] && (ofs == OFS_ACK);
  end

  always_comb begin
    rd_native = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) begin
        case (ofs)
          OFS_EVENTS: rd_native = ev_all[b*BANK_W +: BANK_W];
          OFS_MASK:   rd_native = mk_all[b*BANK_W +: BANK_W];
          OFS_LEVELS: rd_native = lv_all[b*BANK_W +: BANK_W];
          default:    rd_native = '0;
        endcase
      end
    end
  end

  assign bus_rdata = !bus_rd ? '0 : (BIG_ENDIAN ? byte_rev(rd_native) : rd_native);

  AST_BAD_SEL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_ok) |-> bus_rdata == '0); // R5
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_we, ack_we})); // R6
  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ofs == OFS_ACK) |-> bus_rdata == '0); // R6
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 12,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter logic [NUM_BANKS*BANK_W-1:0] LT_PATTERN = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        cpu_irq
);
  logic [NUM_BANKS*BANK_W-1:0] ev_all, mk_all, lv_all;
  logic [NUM_BANKS-1:0]        mask_we, ack_we, pend_next, pend_now;
  word_t                       wdata_n;

  intc_regif #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_all(ev_all), .mk_all(mk_all),
    .lv_all(lv_all), .mask_we(mask_we), .ack_we(ack_we), .wdata_n(wdata_n)
  );

  // Bank b is fed by the input slice of bank number (NUM_BANKS-1-b).
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank #(.LT(LT_PATTERN[b*BANK_W +: BANK_W])) u_bank (
      .clk(clk), .rst_n(rst_n),
      .irq_bits(irq_in[(NUM_BANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we(mask_we[b]), .ack_we(ack_we[b]), .wdata(wdata_n),
      .ev_q(ev_all[b*BANK_W +: BANK_W]), .mk_q(mk_all[b*BANK_W +: BANK_W]),
      .lv_q(lv_all[b*BANK_W +: BANK_W]),
      .pend_next(pend_next[b]), .pend_now(pend_now[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= |pend_next;
  end

  AST_IRQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == |pend_now); // R4
  AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
    $past(!rst_n) |-> !cpu_irq); // R8
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_le, rdata_be;
  logic        irq_le, irq_be;

  always #2 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_le), .cpu_irq(irq_le));
  dual_bank_intc #(.BIG_ENDIAN(1'b1)) u_dual_bank_intc_be (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_be), .cpu_irq(irq_be));

  // kind: 0 LE read data, 1 BE read data, 2 LE irq, 3 BE irq
  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = rdata_le;
        1: act = rdata_be;
        2: act = {31'b0, irq_le};
        default: act = {31'b0, irq_be};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle();
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic push(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1; idle(); bus_addr = a; bus_rd = 1; push(0, e, t);
  endtask

  task automatic rd_be(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1; idle(); bus_addr = a; bus_rd = 1; push(1, e, t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1; idle(); bus_addr = a; bus_wdata = d; bus_wr = 1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1; idle(); push(2, {31'b0, e}, t);
  endtask

  task automatic set_line(input int n, input logic v);
    @(posedge clk); #1; idle(); irq_in[n] = v;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; idle(); rst_n = 0; irq_in = '0;
    @(posedge clk); #1; push(2, 0, "R8 irq low in reset");
    @(posedge clk); #1; rst_n = 1;
  endtask

  initial begin
    do_reset();
    rd(12'h014, 0, "R8 bank0 mask after reset");
    rd(12'h020, 0, "R8 bank1 events after reset");
    rd(12'h02C, 0, "R8 bank1 levels after reset");

    // R1 mapping and R2 edge latching
    set_line(3, 1);
    rd(12'h020, 32'h8, "R1 line3 -> bank1 events");
    rd(12'h02C, 32'h8, "R2 line3 level bit");
    rd(12'h010, 0, "R1 bank0 untouched by line3");
    set_line(35, 1);
    rd(12'h010, 32'h8, "R1 line35 -> bank0 events");
    // R3 low clears only the level
    set_line(3, 0);
    rd(12'h02C, 0, "R3 level cleared");
    rd(12'h020, 32'h8, "R3 event retained");
    // R4/R10 mask enables, registered output
    chk_irq(0, "R4 masked -> no irq");
    @(posedge clk); #1; idle(); bus_addr = 12'h024; bus_wdata = 32'h8; bus_wr = 1;
    push(2, 0, "R10 irq not yet updated during write cycle");
    chk_irq(1, "R4 irq after mask write");
    rd(12'h024, 32'h8, "R6 mask readback");
    rd(12'h028, 0, "R6 ack offset reads zero");
    // R7 acknowledge
    wr(12'h028, 32'h8);
    chk_irq(0, "R7 irq drops after ack");
    rd(12'h020, 0, "R7 event cleared");
    rd(12'h010, 32'h8, "R7 other bank untouched");

    // level-type line 20 in bank 1
    do_reset();
    set_line(20, 1);
    rd(12'h020, 0, "R2 level-type line does not latch");
    rd(12'h02C, 32'h0010_0000, "R2 level-type level bit");
    wr(12'h024, 32'h0010_0000);
    chk_irq(1, "R4 level passthrough raises irq");
    wr(12'h028, 32'hFFFF_FFFF);
    chk_irq(1, "R7 ack cannot clear level-type");
    set_line(20, 0);
    chk_irq(0, "R4 level-type low drops irq");
    set_line(52, 1);
    rd(12'h010, 32'h0010_0000, "R8 bank0 has no level-type bits");

    // R11 set beats clear
    do_reset();
    set_line(4, 1);
    wr(12'h028, 32'h10);
    rd(12'h020, 32'h10, "R11 set wins over ack");
    set_line(4, 0);
    wr(12'h028, 32'h10);
    rd(12'h020, 0, "R11 ack clears once line low");

    // R5/R6 decode holes
    wr(12'h024, 32'h0000_00F0);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h025, 32'hFFFF_FFFF);
    rd(12'h024, 32'h0000_00F0, "R5 stray writes ignored");
    rd(12'h014, 0, "R5 bank0 mask unchanged by stray writes");
    set_line(40, 1);
    rd(12'h030, 0, "R5 index 2 reads zero");
    rd(12'h000, 0, "R5 below window reads zero");
    rd(12'h011, 0, "R6 odd offset reads zero");
    rd(12'h010, 32'h100, "R6 events word at offset 0");

    // R9 byte order
    do_reset();
    wr(12'h024, 32'h0100_0000);
    set_line(0, 1);
    chk_irq(0, "R9 LE mask bit24 does not enable line0");
    @(posedge clk); #1; idle(); push(3, 1, "R9 BE mask enables line0");
    rd_be(12'h020, 32'h0100_0000, "R9 BE event read reversed");
    rd_be(12'h024, 32'h0100_0000, "R9 BE mask read reversed");
    rd(12'h024, 32'h0100_0000, "R9 LE mask read straight");

    @(posedge clk); #1; idle();
    @(posedge clk); #1;
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule